// File: doc/BRIEF.md
# Differential PSK1 Frame Modulator

This block sends a 64-bit tag frame over and over as a load-modulation drive signal for a low-frequency proximity-card emulator. It is clocked by the system clock and moves forward only on cycles where a 1 MHz tick strobe is high. It makes a square subcarrier at one sixteenth of the tick rate. Each data bit lasts sixteen subcarrier cycles. Data is carried differentially: the subcarrier phase inverts at a bit boundary only when the new bit differs from the bit before it. No lock to the reader field is needed.

A frame is a fixed 32-bit preamble followed by a 32-bit card payload. The payload is sent as supplied, so its checksum byte and byte-reversed card number are arranged by the host. A payload written at any time is held in a shadow register. It goes on the air at the next frame start, so a frame never mixes two payloads. A bit strobe and a frame-start marker let surrounding logic follow the transmission.

Top module: `psk1_frame_mod`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `mod_out`, `bit_strobe` and `frame_start` are all low, and the stored payloads clear to zero.
- R2: When `enable` is sampled low, `mod_out`, `bit_strobe` and `frame_start` are low from the next cycle on, and the bit and phase state return to their start values. The first cycle with `enable` high again restarts at frame bit 0, with `frame_start` and `bit_strobe` high in the following cycle.
- R3: The frame is the preamble 0x4944544B followed by the 32-bit payload, sent most-significant bit first.
- R4: The subcarrier half-period is 8 ticks. Frame bit 0 after a start is 0, so the drive is high for its first 8 ticks and low for the next 8.
- R5: Every bit lasts 16 subcarrier cycles (256 ticks). `bit_strobe` is high for one clock in the first cycle of each bit.
- R6: At each bit boundary the subcarrier phase inverts if and only if the new bit differs from the previous one. Before the first bit of a run, the reference is bit value 0 with the drive starting high.
- R7: `mod_out` changes only after a tick, or when the block starts or stops. Phase inversions fall on subcarrier cycle boundaries, so the drive shows no partial pulse.
- R8: After bit 63 the frame restarts at bit 0 with no gap: frame starts are 16384 ticks apart. The previous-bit value carries over from bit 63 to bit 0.
- R9: A payload loaded with `payload_load` takes effect at the next frame start and not before. `frame_start` is high for one clock at each frame start, and only together with `bit_strobe`.
- R10: On cycles with `tick_en` low the modulator state holds, so the bit period measured in clocks scales with the tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 1 MHz time-base strobe, one clock wide |
| enable | input | 1 | Run the modulator; low holds the drive off and restarts the frame |
| payload_in | input | 32 | Card payload, second half of the frame |
| payload_load | input | 1 | Capture `payload_in` into the shadow register |
| mod_out | output | 1 | Load-modulation drive line |
| bit_strobe | output | 1 | One-clock pulse at the start of each bit |
| frame_start | output | 1 | One-clock pulse at the start of each frame |

## Verification
Two payloads are used. One is dense in bit transitions (0xA5C30F96) and one is mostly runs (0x12345678). Together they separate a design that toggles phase on every 1 bit from one that toggles only on a change, and they show whether payload bits are sent in frame order. A reload halfway through a frame separates an immediate latch from one taken at the frame start. Stopping in the middle of a frame and starting again shows whether phase and bit position really restart. Halving the tick rate separates counting ticks from counting clocks.

// File: rtl/psk1_pkg.sv
package psk1_pkg;
    localparam int unsigned PAY_W       = 32;
    localparam int unsigned PRE_W       = 32;
    localparam int unsigned FRAME_W     = PRE_W + PAY_W;
    localparam int unsigned IDX_W       = $clog2(FRAME_W);
    localparam int unsigned HALF_TICKS_D = 8;
    localparam int unsigned CYC_PER_BIT_D = 16;
    localparam logic [PRE_W-1:0] PREAMBLE = 32'h4944544B;

    typedef struct packed {
        logic active;   // modulator running
        logic phase;    // 1 = subcarrier inverted
        logic prev;     // value of the bit now on air
    } seq_state_t;

    typedef struct packed {
        logic bit_go;
        logic frame_go;
    } strobe_t;

    // Bit idx of the frame, counted from the preamble MSB.
    function automatic logic frame_bit(input logic [PAY_W-1:0] pay,
                                       input logic [IDX_W-1:0] idx);
        logic [FRAME_W-1:0] f;
        f = {PREAMBLE, pay} << idx;
        return f[FRAME_W-1];
    endfunction
endpackage

// File: rtl/psk1_subcarrier.sv
module psk1_subcarrier #(
    parameter int unsigned HALF_TICKS     = 8,
    parameter int unsigned CYCLES_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic carrier_hi,
    output logic bit_end
);
    localparam int unsigned TICK_W = $clog2(2 * HALF_TICKS);
    localparam int unsigned CYC_W  = $clog2(CYCLES_PER_BIT);

    logic [TICK_W-1:0] tick_q;
    logic [CYC_W-1:0]  cyc_q;
    logic tick_last, cyc_last;

    assign tick_last  = (tick_q == TICK_W'(2 * HALF_TICKS - 1));
    assign cyc_last   = (cyc_q == CYC_W'(CYCLES_PER_BIT - 1));
    assign carrier_hi = (tick_q < TICK_W'(HALF_TICKS));
    assign bit_end    = adv && tick_last && cyc_last;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tick_q <= '0;
            cyc_q  <= '0;
        end else if (adv) begin
            if (tick_last) begin
                tick_q <= '0;
                cyc_q  <= cyc_last ? '0 : cyc_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/psk1_frame_store.sv
module psk1_frame_store
    import psk1_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PAY_W-1:0] pay_in,
    input  logic             latch,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_val
);
    logic [PAY_W-1:0] shadow_q;
    logic [PAY_W-1:0] live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            live_q   <= '0;
        end else begin
            if (load)  shadow_q <= pay_in;
            if (latch) live_q   <= shadow_q;
        end
    end

    assign bit_val = frame_bit(live_q, idx);
endmodule

// File: rtl/psk1_bit_seq.sv
module psk1_bit_seq
    import psk1_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick_en,
    input  logic             bit_end,
    input  logic             next_bit,
    output logic             adv,
    output logic             clr,
    output logic             latch,
    output logic [IDX_W-1:0] next_idx,
    output logic [IDX_W-1:0] bit_idx,
    output logic             active,
    output logic             phase,
    output logic             bit_strobe,
    output logic             frame_start
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    seq_state_t       st_q;
    strobe_t          stb_q;
    logic [IDX_W-1:0] idx_q;
    logic             activate, wrap, boundary;

    assign activate = enable && !st_q.active;
    assign wrap     = bit_end && (idx_q == LAST_IDX);
    assign boundary = activate || bit_end;
    assign latch    = activate || wrap;
    assign next_idx = (activate || wrap) ? '0 : idx_q + 1'b1;
    assign adv      = st_q.active && enable && tick_en;
    assign clr      = !enable;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st_q  <= '0;
            stb_q <= '0;
            idx_q <= '0;
        end else begin
            st_q.active    <= 1'b1;
            stb_q.bit_go   <= boundary;
            stb_q.frame_go <= latch;
            if (boundary) begin
                idx_q      <= next_idx;
                st_q.phase <= st_q.phase ^ (next_bit ^ st_q.prev);
                st_q.prev  <= next_bit;
            end
        end
    end

    assign bit_idx     = idx_q;
    assign active      = st_q.active;
    assign phase       = st_q.phase;
    assign bit_strobe  = stb_q.bit_go;
    assign frame_start = stb_q.frame_go;
endmodule

// File: rtl/psk1_frame_mod.sv
module psk1_frame_mod
    import psk1_pkg::*;
#(
    parameter int unsigned HALF_TICKS     = HALF_TICKS_D,
    parameter int unsigned CYCLES_PER_BIT = CYC_PER_BIT_D
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        enable,
    input  logic [31:0] payload_in,
    input  logic        payload_load,
    output logic        mod_out,
    output logic        bit_strobe,
    output logic        frame_start
);
    logic             adv, clr, latch, bit_end, carrier_hi;
    logic             next_bit, active, phase;
    logic [IDX_W-1:0] next_idx, bit_idx;

    psk1_subcarrier #(
        .HALF_TICKS    (HALF_TICKS),
        .CYCLES_PER_BIT(CYCLES_PER_BIT)
    ) u_carrier (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .adv       (adv),
        .carrier_hi(carrier_hi),
        .bit_end   (bit_end)
    );

    psk1_frame_store u_store (
        .clk    (clk),
        .rst    (rst),
        .load   (payload_load),
        .pay_in (payload_in),
        .latch  (latch),
        .idx    (next_idx),
        .bit_val(next_bit)
    );

    psk1_bit_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .tick_en    (tick_en),
        .bit_end    (bit_end),
        .next_bit   (next_bit),
        .adv        (adv),
        .clr        (clr),
        .latch      (latch),
        .next_idx   (next_idx),
        .bit_idx    (bit_idx),
        .active     (active),
        .phase      (phase),
        .bit_strobe (bit_strobe),
        .frame_start(frame_start)
    );

    // Phase 0 starts each subcarrier cycle high; phase 1 starts it low.
    assign mod_out = active && (carrier_hi ^ phase);
endmodule

// File: rtl/psk1_frame_mod_chk.sv
module psk1_frame_mod_chk
    import psk1_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             tick_en,
    input logic             mod_out,
    input logic             bit_strobe,
    input logic             frame_start,
    input logic [IDX_W-1:0] bit_idx
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!mod_out && !bit_strobe && !frame_start)); // R1

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!mod_out && !bit_strobe && !frame_start)); // R2

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |=> !bit_strobe); // R5

    AST_NO_GLITCH: assert property (@(posedge clk) disable iff (rst)
        ((mod_out != $past(mod_out)) && !$past(tick_en)) |-> (frame_start || !mod_out)); // R7

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && !frame_start) |-> (bit_idx == IDX_W'($past(bit_idx) + 1'b1))); // R8

    AST_FRAME_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (bit_strobe && bit_idx == '0)); // R9
endmodule

bind psk1_frame_mod psk1_frame_mod_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .tick_en    (tick_en),
    .mod_out    (mod_out),
    .bit_strobe (bit_strobe),
    .frame_start(frame_start),
    .bit_idx    (bit_idx)
);

// File: tb/psk1_frame_mod_tb.sv
`timescale 1ns/1ps
module psk1_frame_mod_tb;
    localparam logic [31:0] PRE = 32'h4944544B;
    localparam logic [31:0] P1  = 32'hA5C30F96;
    localparam logic [31:0] P2  = 32'h12345678;

    logic        clk = 1'b0, rst = 1'b1, tick_en = 1'b1, enable = 1'b0;
    logic        payload_load = 1'b0, half_rate = 1'b0;
    logic [31:0] payload_in = '0;
    logic        mod_out, bit_strobe, frame_start;

    int n_tests = 0, n_fail = 0;

    psk1_frame_mod u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .enable(enable),
        .payload_in(payload_in), .payload_load(payload_load),
        .mod_out(mod_out), .bit_strobe(bit_strobe), .frame_start(frame_start)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        #1;
        tick_en = half_rate ? ~tick_en : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic ref_bit(input logic [31:0] p, input int i);
        logic [63:0] f;
        f = {PRE, p};
        return f[63 - i];
    endfunction

    // Behavioural reference: position within the bit, level of the first half.
    bit m_act = 0, m_hi_first = 1, m_prev = 0, m_bs = 0, m_fs = 0;
    int m_pos = 0, m_bit = 0;
    logic [31:0] m_shadow = '0, m_live = '0;

    always @(posedge clk) begin : model
        logic nb;
        logic [31:0] old_sh;
        old_sh = m_shadow;
        m_bs = 0; m_fs = 0;
        if (rst) begin
            m_act = 0; m_pos = 0; m_bit = 0; m_hi_first = 1; m_prev = 0;
            m_shadow = '0; m_live = '0;
        end else begin
            if (!enable) begin
                m_act = 0; m_pos = 0; m_bit = 0; m_hi_first = 1; m_prev = 0;
            end else if (!m_act) begin
                m_act = 1; m_pos = 0; m_bit = 0; m_live = old_sh;
                m_bs = 1; m_fs = 1;
                nb = ref_bit(m_live, 0);
                if (nb != m_prev) m_hi_first = !m_hi_first;
                m_prev = nb;
            end else if (tick_en) begin
                m_pos++;
                if (m_pos == 256) begin
                    m_pos = 0;
                    m_bit = (m_bit + 1) % 64;
                    if (m_bit == 0) begin
                        m_live = old_sh;
                        m_fs = 1;
                    end
                    m_bs = 1;
                    nb = ref_bit(m_live, m_bit);
                    if (nb != m_prev) m_hi_first = !m_hi_first;
                    m_prev = nb;
                end
            end
            if (payload_load) m_shadow = payload_in;
        end
    end

    // Per-cycle compare and frame capture
    int cyc_n = 0, last_bs = 0, bs_gap = 0, last_fs = 0, fs_gap = 0;
    logic [63:0] dem = '0, last_frame = '0;
    bit exp_mod;

    always @(negedge clk) begin
        if (!rst) begin
            cyc_n++;
            exp_mod = m_act && (((m_pos % 16) < 8) == m_hi_first);
            chk(mod_out === exp_mod, "R6/R7 drive level", 64'(mod_out), 64'(exp_mod));
            chk(bit_strobe === m_bs, "R5 bit strobe", 64'(bit_strobe), 64'(m_bs));
            chk(frame_start === m_fs, "R9 frame start", 64'(frame_start), 64'(m_fs));
            if (bit_strobe) begin
                bs_gap = cyc_n - last_bs;
                last_bs = cyc_n;
                if (frame_start) begin
                    fs_gap = cyc_n - last_fs;
                    last_fs = cyc_n;
                    last_frame = dem;
                end
                dem = {dem[62:0], ~mod_out};
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic wait_fs();
        do step(); while (!frame_start);
        #4;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] pat;
        int bad;
        repeat (5) step();
        chk(!mod_out && !bit_strobe && !frame_start, "R1 outputs quiet in reset",
            {61'd0, mod_out, bit_strobe, frame_start}, 64'd0);
        rst = 1'b0;
        step();
        payload_in = P1; payload_load = 1'b1;
        step();
        payload_load = 1'b0;
        enable = 1'b1;

        // R4: first bit of a frame is 0 -> 8 high then 8 low
        wait_fs();
        pat = '0;
        pat[15] = mod_out;
        for (int i = 14; i >= 0; i--) begin
            step();
            pat[i] = mod_out;
        end
        chk(pat == 16'hFF00, "R4 half-period pattern", 64'(pat), 64'hFF00);

        // R3 frame content, R8 continuous wrap, R5 bit length
        wait_fs();
        chk(last_frame == {PRE, P1}, "R3 frame content", last_frame, {PRE, P1});
        chk(fs_gap == 16384, "R8 frame period", 64'(fs_gap), 64'd16384);
        chk(bs_gap == 256, "R5 bit period across wrap", 64'(bs_gap), 64'd256);

        // R9: reload mid-frame, applied only at next frame start
        repeat (40 * 256) step();
        payload_in = P2; payload_load = 1'b1;
        step();
        payload_load = 1'b0; payload_in = '0;
        wait_fs();
        chk(last_frame == {PRE, P1}, "R9 frame unchanged by mid-frame load", last_frame, {PRE, P1});
        wait_fs();
        chk(last_frame == {PRE, P2}, "R9 new payload at next frame", last_frame, {PRE, P2});

        // R2: stop mid-frame, then restart
        repeat (1000) step();
        enable = 1'b0;
        bad = 0;
        repeat (20) begin
            step();
            if (mod_out || bit_strobe || frame_start) bad++;
        end
        chk(bad == 0, "R2 outputs low while disabled", 64'(bad), 64'd0);
        enable = 1'b1;
        step();
        chk(frame_start && bit_strobe && mod_out, "R2 restart at bit 0",
            {61'd0, frame_start, bit_strobe, mod_out}, 64'd7);

        // R10: half tick rate doubles bit period in clocks
        half_rate = 1'b1;
        repeat (3) begin
            do step(); while (!bit_strobe);
        end
        #4;
        chk(bs_gap == 512, "R10 bit period at half tick rate", 64'(bs_gap), 64'd512);
        summary();
    end
endmodule